// File: doc/BRIEF.md
# Buffered Byte Output Port with Request/Ready Handshake

This block accepts bytes from a host or DMA engine through a simple write port. It keeps them in a small synchronous FIFO and hands them out one at a time on a parallel output bus to an external consumer. The write side exposes a full flag and its complement. A DMA engine can use the not-full flag as its transfer request.

The consumer side uses a four-phase handshake. The consumer raises `req`. The block pops the oldest byte, drives it onto `data_o` and raises `rdy`. It then holds everything until the consumer withdraws `req`, which drops `rdy` one cycle later. If `req` arrives while the FIFO is empty, the block waits with `rdy` low until a byte is written. Everything runs on one clock. `req` is assumed to be synchronous already.

The controller has three states:
- `ST_IDLE`: no transfer is in progress.
- `ST_WAIT`: a request is pending and the FIFO is empty.
- `ST_HOLD`: a byte is presented and `rdy` is high.

Its transitions are:
- **start**: `ST_IDLE`→`ST_HOLD` on `req` with data, which pops the FIFO.
- **starve**: `ST_IDLE`→`ST_WAIT` on `req` with no data.
- **fill**: `ST_WAIT`→`ST_HOLD` once data arrives while `req` is still high, which pops the FIFO.
- **abandon**: `ST_WAIT`→`ST_IDLE` when `req` falls.
- **release**: `ST_HOLD`→`ST_IDLE` when `req` falls.
- In every other case the state stays as it is.

Top module: `pbus_feeder`

## Requirements
- R1: Bytes leave on `data_o` in exactly the order in which they were accepted on the write port.
- R2: The FIFO holds 4 entries. `full` is high and `not_full` low exactly when 4 entries are stored. A write while `full` is high is ignored and leaves the stored contents unchanged.
- R3: In `ST_IDLE`, if `req` is high and the FIFO is non-empty at a clock edge, one byte is popped. `rdy` is high and `data_o` equals that byte from the following cycle.
- R4: `rdy` is high only while a popped byte is presented. While `rdy` and `req` stay high, `rdy` stays high and no further byte is popped.
- R5: When `req` is low at an edge where `rdy` is high, `rdy` is low from the next cycle and the controller is idle.
- R6: If `req` is high while the FIFO is empty, `rdy` stays low. A byte written at edge t is popped at edge t+1, and `rdy` is high after edge t+1.
- R7: If `req` falls while waiting on an empty FIFO, no byte is popped, and a byte written later stays queued.
- R8: `data_o` changes only on a pop. It never changes while `rdy` is high.
- R9: A synchronous active-high `rst` empties the FIFO, clears `rdy`, sets `data_o` to 0 and returns the controller to `ST_IDLE`.
- R10: A write and a pop in the same cycle both take effect when the FIFO was not full before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe from host/DMA |
| wr_data | input | 8 | Byte to enqueue |
| full | output | 1 | FIFO holds 4 entries |
| not_full | output | 1 | Space available; usable as DMA request |
| req | input | 1 | Consumer request |
| rdy | output | 1 | Presented byte is valid |
| data_o | output | 8 | Parallel output byte |

## Verification
The handshake is tried in several ways:
- with `req` held for many cycles after `rdy`, which separates holding from repeated popping;
- with `req` raised on an empty FIFO and then served by a late write, which checks the starve/fill path and its one-cycle pop latency;
- with `req` raised on an empty FIFO and withdrawn before any write, which shows that abandoning consumes nothing.

Writes are also issued beyond capacity and in the same cycle as a pop, which separates dropped writes from accepted ones. A long stretch of random writes and requests is then compared cycle by cycle against a queue model, which exposes any reordering, lost byte or early `rdy`.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_HOLD = 2'd2
    } xfer_state_t;
endpackage

// File: rtl/pbus_fifo.sv
module pbus_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slots[rp];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) slots[wp] <= push_data;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        full && push && !pop |=> full && $stable(wp)) else $error("AST_NO_OVERFLOW"); // R2
    AST_DUAL_OP: assert property (@(posedge clk) disable iff (rst)
        push && pop && !full && !empty |=> $stable(cnt)) else $error("AST_DUAL_OP"); // R10
endmodule

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
    import pbus_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             empty,
    input  logic [WIDTH-1:0] head,
    output logic             pop,
    output logic             rdy,
    output logic [WIDTH-1:0] data_o
);
    xfer_state_t state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req) nxt = empty ? ST_WAIT : ST_HOLD;
            ST_WAIT: if (!req) nxt = ST_IDLE;
                     else if (!empty) nxt = ST_HOLD;
            ST_HOLD: if (!req) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        pop = 1'b0;
        rdy = 1'b0;
        unique case (state)
            ST_IDLE, ST_WAIT: pop = req && !empty;
            ST_HOLD:          rdy = 1'b1;
            default:          ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)      data_o <= '0;
        else if (pop) data_o <= head;
    end

    AST_RDY_HOLD: assert property (@(posedge clk) disable iff (rst)
        rdy && req |=> rdy && !pop) else $error("AST_RDY_HOLD"); // R4
    AST_RDY_DROP: assert property (@(posedge clk) disable iff (rst)
        rdy && !req |=> !rdy) else $error("AST_RDY_DROP"); // R5
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        rdy && req |=> $stable(data_o)) else $error("AST_DATA_STABLE"); // R8
    AST_ABANDON: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) && !req |=> (state == ST_IDLE) && !rdy) else $error("AST_ABANDON"); // R7
endmodule

// File: rtl/pbus_feeder.sv
module pbus_feeder #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             full,
    output logic             not_full,
    input  logic             req,
    output logic             rdy,
    output logic [WIDTH-1:0] data_o
);
    logic             pop, empty;
    logic [WIDTH-1:0] head;

    pbus_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(wr_en), .push_data(wr_data),
        .pop(pop), .head(head), .empty(empty), .full(full)
    );

    pbus_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk(clk), .rst(rst), .req(req), .empty(empty), .head(head),
        .pop(pop), .rdy(rdy), .data_o(data_o)
    );

    assign not_full = !full;

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty) else $error("AST_POP_NONEMPTY"); // R3
    AST_POP_PRESENTS: assert property (@(posedge clk) disable iff (rst)
        pop |=> rdy) else $error("AST_POP_PRESENTS"); // R3
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> !rdy && !full && data_o == '0) else $error("AST_RESET_CLEAR"); // R9
endmodule

// File: tb/sim_pbus_feeder.sv
module sim_pbus_feeder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       req = 1'b0;
    logic       full, not_full, rdy;
    logic [7:0] data_o;

    int total = 0;
    int bad = 0;
    string phase = "R9";

    always #4 clk = ~clk;

    pbus_feeder u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .full(full), .not_full(not_full), .req(req), .rdy(rdy), .data_o(data_o)
    );

    // behavioural reference: 0 idle, 1 waiting, 2 presenting
    logic [7:0] q[$];
    int         m_st = 0;
    logic [7:0] m_data = '0;

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_st = 0;
            m_data = '0;
        end else begin
            bit was_full;
            bit took;
            was_full = (q.size() == 4);
            took = 0;
            if (m_st == 2) begin
                if (!req) m_st = 0;
            end else if (!req) begin
                m_st = 0;
            end else if (q.size() > 0) begin
                m_data = q.pop_front();
                m_st = 2;
                took = 1;
            end else begin
                m_st = 1;
            end
            if (wr_en && !was_full) q.push_back(wr_data);
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s (%s): actual=%0h expected=%0h at %0t", tag, phase, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check("R4 rdy", rdy, (m_st == 2));
            check("R8 data_o", data_o, m_data);
            check("R2 full", full, (q.size() == 4));
            check("R2 not_full", not_full, (q.size() != 4));
        end
    end

    task automatic step(input logic w, input logic [7:0] d, input logic r);
        @(posedge clk);
        #1;
        wr_en = w;
        wr_data = d;
        req = r;
    endtask

    initial begin
        repeat (3000000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(0, 0, 0);
        step(0, 0, 0);
        rst = 1'b0;
        step(0, 0, 0);
        @(negedge clk);
        phase = "R9";
        check("R9 reset rdy", rdy, 0);
        check("R9 reset data", data_o, 0);
        check("R9 reset full", full, 0);

        // fill beyond capacity: fifth write dropped
        phase = "R2";
        for (int i = 0; i < 5; i++) step(1, 8'hA0 + 8'(i), 0);
        step(0, 0, 0);
        @(negedge clk);
        check("R2 full after 5 writes", full, 1);

        // long-held requests, ordering
        phase = "R1 R3";
        for (int k = 0; k < 4; k++) begin
            step(0, 0, 1);
            @(negedge clk);
            @(negedge clk);
            check("R3 rdy after request", rdy, 1);
            check("R1 order", data_o, 8'hA0 + 8'(k));
            repeat (4) step(0, 0, 1);
            phase = "R5";
            step(0, 0, 0);
            @(negedge clk);
            @(negedge clk);
            check("R5 rdy released", rdy, 0);
            phase = "R1 R3";
        end

        // request on empty, late write
        phase = "R6";
        step(0, 0, 1);
        repeat (3) step(0, 0, 1);
        @(negedge clk);
        check("R6 no rdy while empty", rdy, 0);
        step(1, 8'h5C, 1);
        step(0, 0, 1);
        @(negedge clk);
        check("R6 still low one cycle after write", rdy, 0);
        step(0, 0, 1);
        @(negedge clk);
        check("R6 rdy after pop", rdy, 1);
        check("R6 data", data_o, 8'h5C);
        step(0, 0, 0);
        step(0, 0, 0);

        // abandon on empty
        phase = "R7";
        step(0, 0, 1);
        step(0, 0, 1);
        step(0, 0, 0);
        step(1, 8'h77, 0);
        step(0, 0, 0);
        step(0, 0, 0);
        @(negedge clk);
        check("R7 no rdy after abandon", rdy, 0);
        check("R7 stale data kept", data_o, 8'h5C);
        step(0, 0, 1);
        step(0, 0, 1);
        @(negedge clk);
        check("R7 queued byte served", data_o, 8'h77);
        step(0, 0, 0);
        step(0, 0, 0);

        // write and pop together
        phase = "R10";
        step(1, 8'h11, 0);
        step(1, 8'h22, 1);
        step(0, 0, 1);
        @(negedge clk);
        check("R10 popped head", data_o, 8'h11);
        step(0, 0, 0);
        step(0, 0, 1);
        step(0, 0, 1);
        @(negedge clk);
        check("R10 concurrent write kept", data_o, 8'h22);
        step(0, 0, 0);
        step(0, 0, 0);

        // random traffic
        phase = "R1 random";
        begin
            logic r = 0;
            for (int n = 0; n < 4000; n++) begin
                if (($urandom % 4) == 0) r = ~r;
                step(($urandom % 3) != 0, 8'($urandom), r);
            end
        end

        // reset with data present
        phase = "R9";
        step(1, 8'hEE, 0);
        step(1, 8'hEF, 1);
        step(0, 0, 1);
        rst = 1'b1;
        step(0, 0, 0);
        rst = 1'b0;
        step(0, 0, 0);
        @(negedge clk);
        check("R9 rdy cleared", rdy, 0);
        check("R9 fifo emptied", full, 0);
        check("R9 data cleared", data_o, 0);
        step(0, 0, 1);
        step(0, 0, 1);
        @(negedge clk);
        check("R9 nothing left to pop", rdy, 0);
        step(0, 0, 0);
        step(0, 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule